// File: doc/BRIEF.md
# Mailbox Request Sequencer with Retry

This block carries out one request exchange over a message mailbox shared with a supervising agent. A single start pulse hands it a request code and three parameter words. The sequencer first makes sure the previous transmit handshake has drained. It then places the request on four transmit words and raises a valid flag. Once the peer acknowledges, or an acknowledge window runs out, it drops the flag again.

For requests that need a reply, the sequencer watches the first receive word for the matching event code. A match is acknowledged with a one-cycle pulse, and data may be captured from the second and third receive words. If no reply arrives inside the message window, the whole exchange is sent again, up to a fixed number of attempts. All windows are counted in clock cycles, and every request and event code is a parameter.

Top module: `mbx_req_seq`

## Requirements
- R1: After reset, busy, done, error, txValid and rxAck are 0, and version and key are 0.
- R2: Before raising txValid, the sequencer holds it low until it samples txAck low. While txAck stays high, it samples again every CLR_DELAY cycles and does not post.
- R3: When txValid rises, txWord0 carries the request code and txWord1..txWord3 carry parameter words 1..3. txValid falls when txAck is seen, or after ACK_TIMEOUT cycles without it. A missing acknowledge never raises error.
- R4: The reply event each request waits for is fixed. Requests REQ_INIT_ACC (default 1), REQ_FINI_ACC (3) and REQ_RESET_ACC (5) wait for EVT_READY (1). REQ_INIT_DATA (7) waits for EVT_DATA_READY (7).
- R5: REQ_POISON (9) waits for EVT_POISON_READY (9) only when parameter word 1 is nonzero. Any other request code, for example 2, completes without waiting and without error.
- R6: While waiting, rxWord0 equal to the expected event ends the attempt successfully and pulses rxAck for exactly one cycle. Any other value counts as no reply.
- R7: An attempt with no match within MSG_TIMEOUT cycles causes a complete re-post, up to MAX_TRIES (5) posts in total. An attempt that matches ends the request with no further posts.
- R8: If the last attempt fails, done comes with error set. The exception is REQ_INIT_DATA, which completes without error and sets version to 0.
- R9: A successful REQ_INIT_DATA loads version from rxWord1, or loads 1 when rxWord1 is 0. Version is otherwise unchanged.
- R10: A successful REQ_INIT_ACC or REQ_RESET_ACC loads key from rxWord2. All other outcomes leave key unchanged.
- R11: Busy is high from the cycle after start through the cycle of done. Done is a one-cycle pulse, and error is only ever high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begin a request (sampled when idle) |
| reqCode | input | DATA_W | Request code |
| param1 | input | DATA_W | Parameter word 1 |
| param2 | input | DATA_W | Parameter word 2 |
| param3 | input | DATA_W | Parameter word 3 |
| txAck | input | 1 | Peer acknowledge of the transmit words |
| rxWord0 | input | DATA_W | Receive word holding the event code |
| rxWord1 | input | DATA_W | Receive word holding the version |
| rxWord2 | input | DATA_W | Receive word holding the key |
| txWord0 | output | DATA_W | Transmit word: request code |
| txWord1 | output | DATA_W | Transmit word: parameter 1 |
| txWord2 | output | DATA_W | Transmit word: parameter 2 |
| txWord3 | output | DATA_W | Transmit word: parameter 3 |
| txValid | output | 1 | Transmit words are valid |
| rxAck | output | 1 | One-cycle acknowledge of a matched reply |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Request failed (valid with done) |
| version | output | DATA_W | Captured version value |
| key | output | DATA_W | Captured key value |

## Verification
Several corner cases are targeted directly. A reply that first arrives on the third or the fifth attempt must produce exactly that many posts. A design with an off-by-one retry bound would give up one attempt early or post a sixth time.

A wrong event code that persists in rxWord0 must never be acknowledged and must end in error. An unanswered init-data request must end without error and with version 0, where a naive design would flag an error. A version word of 0 must be raised to 1.

A poison request with a zero parameter must finish without waiting. A txAck stuck high must keep txValid low until it is released, and a peer that never acknowledges must still let the exchange finish cleanly. Key must survive failed and unrelated requests.

// File: rtl/mbx_req_pkg.sv
package mbx_req_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLEAR,
    S_HOLD,
    S_ACKWAIT,
    S_RESP,
    S_DONE
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic setValid;
    logic clrValid;
    logic capResp;
    logic zeroVersion;
  } seqStrobe_t;

endpackage

// File: rtl/mbx_req_dpath.sv
module mbx_req_dpath
  import mbx_req_pkg::*;
#(
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned REQ_INIT_ACC    = 1,
  parameter int unsigned REQ_FINI_ACC    = 3,
  parameter int unsigned REQ_RESET_ACC   = 5,
  parameter int unsigned REQ_INIT_DATA   = 7,
  parameter int unsigned REQ_POISON      = 9,
  parameter int unsigned EVT_READY       = 1,
  parameter int unsigned EVT_DATA_READY  = 7,
  parameter int unsigned EVT_POISON_READY = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] reqCode,
  input  logic [DATA_W-1:0] param1,
  input  logic [DATA_W-1:0] param2,
  input  logic [DATA_W-1:0] param3,
  input  logic [DATA_W-1:0] rxWord0,
  input  logic [DATA_W-1:0] rxWord1,
  input  logic [DATA_W-1:0] rxWord2,
  output logic [DATA_W-1:0] txWord0,
  output logic [DATA_W-1:0] txWord1,
  output logic [DATA_W-1:0] txWord2,
  output logic [DATA_W-1:0] txWord3,
  output logic              txValid,
  output logic              rxAck,
  output logic [DATA_W-1:0] version,
  output logic [DATA_W-1:0] key,
  output logic              expectWait,
  output logic              rxMatch,
  output logic              isInitData
);

  localparam logic [DATA_W-1:0] C_INIT_ACC  = DATA_W'(REQ_INIT_ACC);
  localparam logic [DATA_W-1:0] C_FINI_ACC  = DATA_W'(REQ_FINI_ACC);
  localparam logic [DATA_W-1:0] C_RESET_ACC = DATA_W'(REQ_RESET_ACC);
  localparam logic [DATA_W-1:0] C_INIT_DATA = DATA_W'(REQ_INIT_DATA);
  localparam logic [DATA_W-1:0] C_POISON    = DATA_W'(REQ_POISON);
  localparam logic [DATA_W-1:0] E_READY     = DATA_W'(EVT_READY);
  localparam logic [DATA_W-1:0] E_DATA      = DATA_W'(EVT_DATA_READY);
  localparam logic [DATA_W-1:0] E_POISON    = DATA_W'(EVT_POISON_READY);
  localparam logic [DATA_W-1:0] ONE         = DATA_W'(1);

  logic [DATA_W-1:0] reqR, p1R, p2R, p3R;
  logic [DATA_W-1:0] expEvent;
  logic              isAccess, isKeyReq, isPoisonWait;

  // Latched request words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqR <= '0;
      p1R  <= '0;
      p2R  <= '0;
      p3R  <= '0;
    end else if (strb.loadReq) begin
      reqR <= reqCode;
      p1R  <= param1;
      p2R  <= param2;
      p3R  <= param3;
    end
  end

  // Reply decode
  always_comb begin
    isAccess     = (reqR == C_INIT_ACC) || (reqR == C_FINI_ACC) || (reqR == C_RESET_ACC);
    isKeyReq     = (reqR == C_INIT_ACC) || (reqR == C_RESET_ACC);
    isInitData   = (reqR == C_INIT_DATA);
    isPoisonWait = (reqR == C_POISON) && (p1R != '0);
    expectWait   = isAccess || isInitData || isPoisonWait;
    if (isInitData)        expEvent = E_DATA;
    else if (isPoisonWait) expEvent = E_POISON;
    else                   expEvent = E_READY;
    rxMatch = (rxWord0 == expEvent);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      rxAck   <= 1'b0;
      version <= '0;
      key     <= '0;
    end else begin
      if (strb.setValid)      txValid <= 1'b1;
      else if (strb.clrValid) txValid <= 1'b0;
      rxAck <= strb.capResp;
      if (strb.zeroVersion)
        version <= '0;
      else if (strb.capResp && isInitData)
        version <= (rxWord1 == '0) ? ONE : rxWord1;
      if (strb.capResp && isKeyReq)
        key <= rxWord2;
    end
  end

  assign txWord0 = reqR;
  assign txWord1 = p1R;
  assign txWord2 = p2R;
  assign txWord3 = p3R;

endmodule

// File: rtl/mbx_req_ctrl.sv
module mbx_req_ctrl
  import mbx_req_pkg::*;
#(
  parameter int unsigned ACK_TIMEOUT = 8,
  parameter int unsigned MSG_TIMEOUT = 20,
  parameter int unsigned CLR_DELAY   = 3,
  parameter int unsigned MAX_TRIES   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       txAck,
  input  logic       expectWait,
  input  logic       rxMatch,
  input  logic       isInitData,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       error
);

  localparam int unsigned MAX_WIN = (ACK_TIMEOUT > MSG_TIMEOUT) ?
                                    ((ACK_TIMEOUT > CLR_DELAY) ? ACK_TIMEOUT : CLR_DELAY) :
                                    ((MSG_TIMEOUT > CLR_DELAY) ? MSG_TIMEOUT : CLR_DELAY);
  localparam int unsigned CNT_W = $clog2(MAX_WIN + 1);
  localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] MSG_LAST = CNT_W'(MSG_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_DELAY - 1);
  localparam logic [TRY_W-1:0] TRY_MAX  = TRY_W'(MAX_TRIES);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [TRY_W-1:0] tries, triesNxt;
  logic             errR, errNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    triesNxt = tries;
    errNxt   = errR;
    strb     = '0;
    unique case (state)
      S_IDLE: begin
        if (startPulse) begin
          strb.loadReq = 1'b1;
          triesNxt     = TRY_W'(1);
          errNxt       = 1'b0;
          stateNxt     = S_CLEAR;
        end
      end
      S_CLEAR: begin
        cntNxt = '0;
        if (!txAck) begin
          strb.setValid = 1'b1;
          stateNxt      = S_ACKWAIT;
        end else begin
          strb.clrValid = 1'b1;
          stateNxt      = S_HOLD;
        end
      end
      S_HOLD: begin
        cntNxt = cnt + 1'b1;
        if (cnt >= CLR_LAST) stateNxt = S_CLEAR;
      end
      S_ACKWAIT: begin
        cntNxt = cnt + 1'b1;
        if (txAck || cnt >= ACK_LAST) begin
          strb.clrValid = 1'b1;
          cntNxt        = '0;
          stateNxt      = expectWait ? S_RESP : S_DONE;
        end
      end
      S_RESP: begin
        cntNxt = cnt + 1'b1;
        if (rxMatch) begin
          strb.capResp = 1'b1;
          stateNxt     = S_DONE;
        end else if (cnt >= MSG_LAST) begin
          if (tries < TRY_MAX) begin
            triesNxt = tries + 1'b1;
            stateNxt = S_CLEAR;
          end else begin
            if (isInitData) strb.zeroVersion = 1'b1;
            else            errNxt = 1'b1;
            stateNxt = S_DONE;
          end
        end
      end
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      tries <= '0;
      errR  <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      tries <= triesNxt;
      errR  <= errNxt;
    end
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);
  assign error = done && errR;

endmodule

// File: rtl/mbx_req_seq.sv
module mbx_req_seq
  import mbx_req_pkg::*;
#(
  parameter int unsigned DATA_W           = 32,
  parameter int unsigned ACK_TIMEOUT      = 8,
  parameter int unsigned MSG_TIMEOUT      = 20,
  parameter int unsigned CLR_DELAY        = 3,
  parameter int unsigned MAX_TRIES        = 5,
  parameter int unsigned REQ_INIT_ACC     = 1,
  parameter int unsigned REQ_FINI_ACC     = 3,
  parameter int unsigned REQ_RESET_ACC    = 5,
  parameter int unsigned REQ_INIT_DATA    = 7,
  parameter int unsigned REQ_POISON       = 9,
  parameter int unsigned EVT_READY        = 1,
  parameter int unsigned EVT_DATA_READY   = 7,
  parameter int unsigned EVT_POISON_READY = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [DATA_W-1:0] reqCode,
  input  logic [DATA_W-1:0] param1,
  input  logic [DATA_W-1:0] param2,
  input  logic [DATA_W-1:0] param3,
  input  logic              txAck,
  input  logic [DATA_W-1:0] rxWord0,
  input  logic [DATA_W-1:0] rxWord1,
  input  logic [DATA_W-1:0] rxWord2,
  output logic [DATA_W-1:0] txWord0,
  output logic [DATA_W-1:0] txWord1,
  output logic [DATA_W-1:0] txWord2,
  output logic [DATA_W-1:0] txWord3,
  output logic              txValid,
  output logic              rxAck,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] version,
  output logic [DATA_W-1:0] key
);

  seqStrobe_t strb;
  logic       expectWait, rxMatch, isInitData;

  mbx_req_ctrl #(
    .ACK_TIMEOUT(ACK_TIMEOUT), .MSG_TIMEOUT(MSG_TIMEOUT),
    .CLR_DELAY(CLR_DELAY), .MAX_TRIES(MAX_TRIES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .txAck(txAck),
    .expectWait(expectWait), .rxMatch(rxMatch), .isInitData(isInitData),
    .strb(strb), .busy(busy), .done(done), .error(error)
  );

  mbx_req_dpath #(
    .DATA_W(DATA_W), .REQ_INIT_ACC(REQ_INIT_ACC), .REQ_FINI_ACC(REQ_FINI_ACC),
    .REQ_RESET_ACC(REQ_RESET_ACC), .REQ_INIT_DATA(REQ_INIT_DATA),
    .REQ_POISON(REQ_POISON), .EVT_READY(EVT_READY),
    .EVT_DATA_READY(EVT_DATA_READY), .EVT_POISON_READY(EVT_POISON_READY)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqCode(reqCode),
    .param1(param1), .param2(param2), .param3(param3),
    .rxWord0(rxWord0), .rxWord1(rxWord1), .rxWord2(rxWord2),
    .txWord0(txWord0), .txWord1(txWord1), .txWord2(txWord2), .txWord3(txWord3),
    .txValid(txValid), .rxAck(rxAck), .version(version), .key(key),
    .expectWait(expectWait), .rxMatch(rxMatch), .isInitData(isInitData)
  );

endmodule

// File: rtl/mbx_req_seq_chk.sv
module mbx_req_seq_chk (
  input logic clk,
  input logic rstN,
  input logic txAck,
  input logic txValid,
  input logic rxAck,
  input logic busy,
  input logic done,
  input logic error
);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> !$past(txAck));

  // R3
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !txValid);

  // R6
  rxack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxAck |=> !rxAck);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R11
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

endmodule

bind mbx_req_seq mbx_req_seq_chk u_seq_chk (
  .clk(clk), .rstN(rstN), .txAck(txAck), .txValid(txValid), .rxAck(rxAck),
  .busy(busy), .done(done), .error(error)
);

// File: tb/mbx_req_seq_bench.sv
module mbx_req_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACK_T = 8;
  localparam int MSG_T = 20;
  localparam int CLR_D = 3;
  localparam int NV = 12;

  // Columns: request, param1, reply code, unanswered attempts, rxWord1, rxWord2,
  // expected error, version, key, posts, acknowledges
  localparam logic [31:0] V_REQ [NV]  = '{1, 5, 3, 7, 7, 7, 9, 9, 9, 1, 2, 1};
  localparam logic [31:0] V_P1  [NV]  = '{0, 0, 0, 0, 0, 0, 0, 4, 4, 0, 0, 0};
  localparam logic [31:0] V_RPL [NV]  = '{1, 1, 1, 7, 7, 7, 9, 9, 9, 7, 1, 1};
  localparam logic [31:0] V_FAIL[NV]  = '{0, 2, 9, 0, 1, 9, 0, 0, 9, 0, 0, 4};
  localparam logic [31:0] V_W1  [NV]  = '{0, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [31:0] V_W2  [NV]  = '{32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003, 32'hDDDD0004,
                                         0, 0, 0, 0, 0, 32'hEEEE0006, 0, 32'hFFFF0005};
  localparam logic [31:0] V_ERR [NV]  = '{0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0};
  localparam logic [31:0] V_VER [NV]  = '{0, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [31:0] V_KEY [NV]  = '{32'hAAAA0001, 32'hBBBB0002, 32'hBBBB0002, 32'hBBBB0002,
                                         32'hBBBB0002, 32'hBBBB0002, 32'hBBBB0002, 32'hBBBB0002,
                                         32'hBBBB0002, 32'hBBBB0002, 32'hBBBB0002, 32'hFFFF0005};
  localparam logic [31:0] V_POST[NV]  = '{1, 3, 5, 1, 2, 5, 1, 1, 5, 5, 1, 5};
  localparam logic [31:0] V_ACKS[NV]  = '{1, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0, 1};

  logic clk = 1'b0, rstN = 1'b0, startPulse = 1'b0;
  logic [31:0] reqCode = '0, param1 = '0, param2 = '0, param3 = '0;
  logic txAck;
  logic [31:0] rxWord0, rxWord1 = '0, rxWord2 = '0;
  logic [31:0] txWord0, txWord1, txWord2, txWord3;
  logic txValid, rxAck, busy, done, error;
  logic [31:0] version, key;

  // Responder control
  logic        ackEn = 1'b1, stuckAck = 1'b0, clrStats = 1'b0;
  logic [31:0] replyCode = '0, failCnt = '0;
  logic [31:0] posts, acks;
  logic        wordsBad, prevValid;
  logic [3:0]  ackCnt;

  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_req_seq #(.ACK_TIMEOUT(ACK_T), .MSG_TIMEOUT(MSG_T), .CLR_DELAY(CLR_D)) u_mbx_req_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .reqCode(reqCode),
    .param1(param1), .param2(param2), .param3(param3), .txAck(txAck),
    .rxWord0(rxWord0), .rxWord1(rxWord1), .rxWord2(rxWord2),
    .txWord0(txWord0), .txWord1(txWord1), .txWord2(txWord2), .txWord3(txWord3),
    .txValid(txValid), .rxAck(rxAck), .busy(busy), .done(done), .error(error),
    .version(version), .key(key)
  );

  // Behavioural peer
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txAck <= 1'b0; rxWord0 <= '0; posts <= '0; acks <= '0;
      wordsBad <= 1'b0; prevValid <= 1'b0; ackCnt <= '0;
    end else begin
      prevValid <= txValid;
      ackCnt    <= txValid ? ((ackCnt == 4'hF) ? ackCnt : ackCnt + 4'd1) : 4'd0;
      txAck     <= stuckAck || (ackEn && txValid && ackCnt >= 4'd1);
      if (clrStats) begin
        posts <= '0; acks <= '0; wordsBad <= 1'b0;
      end else begin
        if (txValid && !prevValid) begin
          posts <= posts + 1;
          if (txWord0 !== reqCode || txWord1 !== param1 ||
              txWord2 !== param2 || txWord3 !== param3) wordsBad <= 1'b1;
        end
        if (rxAck) acks <= acks + 1;
      end
      if (txValid && !prevValid)                     rxWord0 <= '0;
      else if (rxAck)                                rxWord0 <= '0;
      else if (txValid && txAck && posts > failCnt)  rxWord0 <= replyCode;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearStats();
    @(negedge clk); clrStats = 1'b1;
    @(negedge clk); clrStats = 1'b0;
  endtask

  logic gotErr, gotValid;
  int   waitCyc;

  task automatic runReq(input logic [31:0] rq, input logic [31:0] p1);
    @(negedge clk);
    reqCode = rq; param1 = p1; param2 = rq ^ 32'h5A5A0000; param3 = ~rq;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R11 busy after start", {31'd0, busy}, 32'd1);
    waitCyc = 1;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    gotErr = error; gotValid = txValid;
    chk("R11 done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R11 done single pulse", {31'd0, done}, 32'd0);
    chk("R11 busy low after done", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 error", {31'd0, error}, 0);
    chk("R1 txValid", {31'd0, txValid}, 0);
    chk("R1 rxAck", {31'd0, rxAck}, 0);
    chk("R1 version", version, 0);
    chk("R1 key", key, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      replyCode = V_RPL[i]; failCnt = V_FAIL[i];
      rxWord1 = V_W1[i]; rxWord2 = V_W2[i];
      clearStats();
      runReq(V_REQ[i], V_P1[i]);
      chk($sformatf("R8 error vec%0d", i), {31'd0, gotErr}, V_ERR[i]);
      chk($sformatf("R3 valid cleared vec%0d", i), {31'd0, gotValid}, 0);
      chk($sformatf("R3 tx words vec%0d", i), {31'd0, wordsBad}, 0);
      chk($sformatf("R7 posts vec%0d", i), posts, V_POST[i]);
      chk($sformatf("R6 rx acks vec%0d", i), acks, V_ACKS[i]);
      chk($sformatf("R9 version vec%0d", i), version, V_VER[i]);
      chk($sformatf("R10 key vec%0d", i), key, V_KEY[i]);
    end

    // R3: peer never acknowledges; no-reply request still completes cleanly
    ackEn = 1'b0; failCnt = 32'd9;
    clearStats();
    runReq(32'd2, 32'd0);
    chk("R3 ack timeout no error", {31'd0, gotErr}, 0);
    chk("R3 ack timeout one post", posts, 1);
    chk("R3 ack timeout window", {31'd0, waitCyc >= ACK_T}, 1);
    chk("R5 no wait no ack pulse", acks, 0);
    ackEn = 1'b1;

    // R2: stuck txAck blocks posting until released
    clearStats();
    stuckAck = 1'b1;
    @(negedge clk);
    reqCode = 32'd2; param1 = '0; param2 = 32'h5A5A0002; param3 = ~32'd2;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 no post while ack high", posts, 0);
    chk("R2 txValid low while ack high", {31'd0, txValid}, 0);
    chk("R11 busy while blocked", {31'd0, busy}, 1);
    stuckAck = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    chk("R2 posted after release", posts, 1);
    chk("R2 error after release", {31'd0, error}, 0);
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule